// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block divides a system clock down to a slower clock for an analog converter. The length of the high phase and the length of the low phase are programmed separately. A 5-bit high-time setting and a 3-bit low-time setting together fix the output period. A half-cycle adjust bit moves the falling edge half a system clock later, which changes the duty cycle and leaves the period as it is.

One down counter times both phases. It is loaded with the high-time setting when a high phase begins, and the high phase ends when the counter reaches zero. In the low phase the counter keeps counting down through zero and wraps. The low phase ends when its three lowest bits equal the bitwise inverse of the low-time setting. A register clocked on the falling edge holds the output high for half a cycle more when the adjust bit is set. The settings are taken only when a high phase starts. A one-clock pulse marks each high-phase start, so the converter logic can count output periods without using the divided clock as a clock.

The pins are plain control inputs and a clock-like output. There is no data stream and no handshake.

Top module: `psc_duty_prescaler`

## Requirements
- R1: While `rst_n` is low, `div_clk` and `high_start` are 0. At the first rising edge of `clk` after release, a high phase starts: `div_clk` goes to 1 and `high_start` goes to 1.
- R2: With `half_adj` = 0, each high phase of `div_clk` lasts `hi_len` + 1 clock periods.
- R3: With `half_adj` = 0, each low phase lasts `lo_len` + 1 clock periods. The low phase ends on the clock in which the three low bits of the shared counter, still counting down past zero, equal the bitwise inverse of `lo_len`.
- R4: With `half_adj` = 1, the falling edge of `div_clk` moves half a clock period later. The high phase lasts `hi_len` + 1.5 periods and the low phase lasts `lo_len` + 0.5 periods.
- R5: The output period is `hi_len` + `lo_len` + 2 clock periods for both values of `half_adj`.
- R6: `high_start` is high for exactly one clock per output period. That clock is the first clock of each high phase.
- R7: `hi_len`, `lo_len` and `half_adj` are sampled only when a high phase starts. A change made during a period does not alter that period's high or low phase. It applies from the next high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_len | input | 5 | High-phase length minus one, in clock periods |
| lo_len | input | 3 | Low-phase length minus one, in clock periods |
| half_adj | input | 1 | Delays the falling edge by half a clock period |
| div_clk | output | 1 | Divided converter clock |
| high_start | output | 1 | One-clock pulse at each high-phase start |

## Verification
The output is sampled twice per clock, between edges, so each phase length is measured in half-period units. The bench runs every low-time setting with both adjust values against high-time settings from 0 to 31. These runs separate errors in the high count, in the low-phase match against the inverted setting, and in the half-cycle stretch, which each give a different pair of phase lengths. A reset run checks the phase length from the first edge after release. A run that changes all three settings during a high phase shows whether a running period is shortened, and then whether the next period uses the new values.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DEF_HI_W = 5;
  localparam int DEF_LO_W = 3;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/psc_cfg_latch.sv
module psc_cfg_latch #(
  parameter int LO_W = psc_pkg::DEF_LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LO_W-1:0] lo_len,
  input  logic            half_adj,
  output logic [LO_W-1:0] lo_q,
  output logic            psa_q
);
  // Low-time and adjust settings are captured only at a phase start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      psa_q <= 1'b0;
    end else if (load) begin
      lo_q  <= lo_len;
      psa_q <= half_adj;
    end
  end

  // R7: held settings only move on a load.
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({lo_q, psa_q}));
endmodule

// File: rtl/psc_phase_ctr.sv
module psc_phase_ctr
  import psc_pkg::*;
#(
  parameter int HI_W = DEF_HI_W,
  parameter int LO_W = DEF_LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] hi_len,
  input  logic [LO_W-1:0] lo_q,
  output phase_e          ph,
  output logic            load,
  output logic            high_start
);
  logic [HI_W-1:0] cnt;
  logic            arm;
  logic            hi_done;
  logic            lo_done;

  // The high phase ends at zero. The low phase keeps counting through the
  // wrap and ends when the low bits match the inverted low-time setting.
  assign hi_done = (ph == PH_HIGH) && (cnt == '0);
  assign lo_done = (ph == PH_LOW) && (cnt[LO_W-1:0] == ~lo_q);
  assign load    = arm | lo_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ph         <= PH_LOW;
      arm        <= 1'b1;
      high_start <= 1'b0;
    end else begin
      arm        <= 1'b0;
      high_start <= load;
      if (load) begin
        cnt <= hi_len;
        ph  <= PH_HIGH;
      end else begin
        cnt <= cnt - 1'b1;
        if (hi_done) ph <= PH_LOW;
      end
    end
  end

  // R6: the start pulse never lasts two clocks.
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |=> !high_start);

  // R6: the pulse lines up with a low-to-high phase change.
  p_pulse_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    high_start |-> (ph == PH_HIGH) && ($past(ph) == PH_LOW));

  // R3: during the low phase the counter keeps stepping down, wrapping past zero.
  p_low_wraps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_LOW) && ($past(ph) == PH_LOW) && !arm)
      |-> (cnt == HI_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/psc_half_stretch.sv
module psc_half_stretch
  import psc_pkg::*;
#(
  parameter bit HALF_EN = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph,
  input  logic   psa_q,
  output logic   div_out
);
  logic ph_hi;
  assign ph_hi = (ph == PH_HIGH);

  generate
    if (HALF_EN) begin : g_half
      logic hold_q;
      // Falling-edge copy keeps the output high half a cycle after the phase drops.
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= 1'b0;
        else        hold_q <= ph_hi;
      end
      assign div_out = ph_hi | (psa_q & hold_q);
    end else begin : g_plain
      logic unused_psa;
      assign unused_psa = psa_q;
      assign div_out    = ph_hi;
    end
  endgenerate

  // R4: from the second low clock on, the stretch has ended.
  p_stretch_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_LOW) && ($past(ph) == PH_LOW)) |-> !div_out);
endmodule

// File: rtl/psc_duty_prescaler.sv
module psc_duty_prescaler
  import psc_pkg::*;
#(
  parameter int HI_W    = DEF_HI_W,
  parameter int LO_W    = DEF_LO_W,
  parameter bit HALF_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] hi_len,
  input  logic [LO_W-1:0] lo_len,
  input  logic            half_adj,
  output logic            div_clk,
  output logic            high_start
);
  phase_e          ph;
  logic            load;
  logic [LO_W-1:0] lo_q;
  logic            psa_q;

  psc_cfg_latch #(.LO_W(LO_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .lo_len   (lo_len),
    .half_adj (half_adj),
    .lo_q     (lo_q),
    .psa_q    (psa_q)
  );

  psc_phase_ctr #(.HI_W(HI_W), .LO_W(LO_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_len     (hi_len),
    .lo_q       (lo_q),
    .ph         (ph),
    .load       (load),
    .high_start (high_start)
  );

  psc_half_stretch #(.HALF_EN(HALF_EN)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph),
    .psa_q   (psa_q),
    .div_out (div_clk)
  );
endmodule

// File: tb/sim_psc_duty_prescaler.sv
`timescale 1ns/1ps
module sim_psc_duty_prescaler;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] hi_len;
  logic [2:0] lo_len;
  logic       half_adj;
  logic       div_clk;
  logic       high_start;

  int nvec = 0;
  int nerr = 0;
  bit done = 0;
  bit pend_rise = 0;
  bit pend_hs = 0;

  always #4 clk = ~clk;

  psc_duty_prescaler u0 (
    .clk(clk), .rst_n(rst_n), .hi_len(hi_len), .lo_len(lo_len),
    .half_adj(half_adj), .div_clk(div_clk), .high_start(high_start)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One sample per half clock, taken 2 ns after each edge.
  task automatic half(output bit d, output bit hs);
    @(clk);
    #2;
    d  = div_clk;
    hs = high_start;
  endtask

  task automatic set_cfg(input int h, input int l, input bit a);
    hi_len    = 5'(h);
    lo_len    = 3'(l);
    half_adj  = a;
    pend_rise = 0;
  endtask

  task automatic sync_rise(output bit hs0, output bit ok);
    bit d, hs, p;
    ok = 0;
    if (pend_rise) begin
      pend_rise = 0; hs0 = pend_hs; ok = 1; return;
    end
    p = 1;
    for (int i = 0; i < 400; i++) begin
      half(d, hs);
      if (!p && d) begin hs0 = hs; ok = 1; return; end
      p = d;
    end
  endtask

  // Measures one period from a rising edge, in half-clock units.
  task automatic run_period(input bit chg, input int nh, input int nl, input bit na,
                            output int hi, output int lo, output int hs0, output int hs_tot);
    bit d, hs, h0, ok;
    hi = 0; lo = 0; hs_tot = 0; hs0 = 0;
    sync_rise(h0, ok);
    if (!ok) begin
      chk(0, "R5 no rising edge found", 0, 1);
      return;
    end
    hs0 = h0; hi = 1; hs_tot = int'(h0);
    if (chg) begin
      hi_len = 5'(nh); lo_len = 3'(nl); half_adj = na;
    end
    for (int i = 0; i < 200; i++) begin
      half(d, hs);
      if (!d) begin lo = 1; break; end
      hi++; hs_tot += int'(hs);
    end
    for (int i = 0; i < 200; i++) begin
      half(d, hs);
      if (d) begin pend_rise = 1; pend_hs = hs; break; end
      lo++; hs_tot += int'(hs);
    end
  endtask

  task automatic t_reset();
    int hi, lo, hs0, tot;
    rst_n = 0;
    set_cfg(3, 2, 0);
    repeat (3) @(posedge clk);
    #2;
    chk(div_clk == 1'b0, "R1 div_clk in reset", div_clk, 0);
    chk(high_start == 1'b0, "R1 high_start in reset", high_start, 0);
    @(negedge clk); #2;
    rst_n = 1;
    @(posedge clk); #2;
    chk(div_clk == 1'b1, "R1 div_clk after release", div_clk, 1);
    chk(high_start == 1'b1, "R1 high_start after release", high_start, 1);
    pend_rise = 1; pend_hs = high_start;
    run_period(0, 0, 0, 0, hi, lo, hs0, tot);
    chk(hi == 8, "R1 first high length (halves)", hi, 8);
    chk(lo == 6, "R1 first low length (halves)", lo, 6);
  endtask

  task automatic t_sweep();
    int hs_list[6] = '{0, 1, 2, 5, 13, 31};
    int hi, lo, hs0, tot, eh, el;
    foreach (hs_list[k]) begin
      for (int l = 0; l < 8; l++) begin
        for (int a = 0; a < 2; a++) begin
          set_cfg(hs_list[k], l, a[0]);
          run_period(0, 0, 0, 0, hi, lo, hs0, tot);
          eh = 2 * (hs_list[k] + 1) + a;
          el = 2 * (l + 1) - a;
          chk(hi == eh, (a != 0) ? "R4 high length" : "R2 high length", hi, eh);
          chk(lo == el, (a != 0) ? "R4 low length" : "R3 low length", lo, el);
          chk(hi + lo == 2 * (hs_list[k] + l + 2), "R5 period", hi + lo, 2 * (hs_list[k] + l + 2));
          chk(hs0 == 1, "R6 pulse at high start", hs0, 1);
          chk(tot == 2, "R6 pulse width per period (halves)", tot, 2);
        end
      end
    end
  endtask

  task automatic t_midchange();
    int hi, lo, hs0, tot;
    set_cfg(6, 1, 0);
    run_period(1, 2, 5, 1, hi, lo, hs0, tot);
    chk(hi == 14, "R7 running high kept", hi, 14);
    chk(lo == 4, "R7 running low kept", lo, 4);
    run_period(0, 0, 0, 0, hi, lo, hs0, tot);
    chk(hi == 7, "R7 next high uses new value", hi, 7);
    chk(lo == 11, "R7 next low uses new value", lo, 11);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_midchange();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule